// File: doc/BRIEF.md
# Memory Controller Configuration Register Block

This block holds the configuration and status state of an external memory controller. Software reaches every register through an address/data port pair: a write to the pointer port sets a 32-bit register offset, and reads and writes on the data port then act on the register that offset names. The block stores error, refresh, timing, power-management and ECC settings, and keeps a small status word that follows edges of the configuration register.

The block also decodes up to four bank configuration words into a byte base address, a size in MiB and a mapped flag for each bank. These feed the address decoder of the memory controller. A bank counts as mapped only while its own valid bit and the global enable bit are both set. A level interrupt stays raised while the ECC error register holds a nonzero value.

Top module: `memctl_cfg_regs`

## Requirements
- R1: A write with `acc_port`=0 stores all 32 bits of `acc_wdata` as the offset pointer. Reads with `acc_port`=0 return that pointer. Reads and writes with `acc_port`=1 act on the register at the pointer offset.
- R2: After reset the registers read as follows: power-management (0x34) 0x07C00000, refresh (0x30) 0x05F00000, timing (0x80) 0x00854009, configuration (0x20) 0x00800000. The pointer and every other register read zero.
- R3: The error status registers at 0x00 and 0x08 clear each bit written as 1 and keep the others. The error address register at 0x10 stores the full written value.
- R4: The configuration register at 0x20 stores the full written value. If a write takes its bit 31 from 0 to 1, status (0x24) bit 31 clears. If a write takes it from 1 to 0, status bit 31 sets.
- R5: If a write takes configuration bit 30 from 0 to 1, status bit 30 sets. If it takes bit 30 from 1 to 0, status bit 30 clears.
- R6: Data-port writes to the status register at 0x24 leave it unchanged.
- R7: Writes store these values: refresh (0x30) keeps value AND 0x3FF80000, timing (0x80) keeps value AND 0x018FC01F, ECC configuration (0x94) keeps value AND 0x00F00000.
- R8: The power-management register (0x34) stores (value AND 0xF8000000) OR 0x07C00000.
- R9: Bank configuration writes at 0x40, 0x44, 0x48 and 0x4C (bank 0..3) store value AND 0xFFDEE001.
- R10: For each bank, `bank_base` is the bank word AND 0xFF800000. `bank_size_mib` is 4 shifted left by bank word bits 19:17 for codes 0..6 (4 to 256 MiB), and 0 for code 7.
- R11: `bank_mapped[i]` is high exactly when bank word bit 0 and configuration bit 31 are both set.
- R12: `ecc_irq` rises when a write to 0x98 takes the ECC error register from zero to nonzero. It falls when a write returns it to zero. The register stores the full written value.
- R13: Data-port reads at any other pointer value return zero, including pointers with bits above bit 7 set. Writes there change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Access strobe for one cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_port | input | 1 | 0 = pointer port, 1 = data port |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data for the selected port (combinational) |
| bank_base | output | NUM_BANKS*32 | Per-bank byte base address, bank i in bits [32i+31:32i] |
| bank_size_mib | output | NUM_BANKS*10 | Per-bank size in MiB, bank i in bits [10i+9:10i] |
| bank_mapped | output | NUM_BANKS | Per-bank mapped flag |
| ecc_irq | output | 1 | ECC error interrupt level |

## Verification
The bench builds the block with its default of four banks, so all four bank offsets and the address just past them (0x50) are reachable. The bench drives size codes 0, 6 and 7 and both settings of the valid bit. It steps the global enable through every transition of bits 31 and 30, repeats a nonzero ECC error write, and drives pointers with high bits set, so that every status edge, every forced and masked field and every unmapped read is compared against the behavioural model.

// File: rtl/memcfg_pkg.sv
package memcfg_pkg;

    localparam int unsigned DATA_W      = 32;
    localparam int unsigned SIZE_W      = 10;
    localparam int unsigned BANK_STRIDE = 4;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic {
        PORT_PTR  = 1'b0,
        PORT_DATA = 1'b1
    } port_e;

    // register offsets
    localparam word_t OFS_ERR0    = 32'h0000_0000;
    localparam word_t OFS_ERR1    = 32'h0000_0008;
    localparam word_t OFS_ERRADDR = 32'h0000_0010;
    localparam word_t OFS_CTRL    = 32'h0000_0020;
    localparam word_t OFS_STAT    = 32'h0000_0024;
    localparam word_t OFS_REFRESH = 32'h0000_0030;
    localparam word_t OFS_PWR     = 32'h0000_0034;
    localparam word_t OFS_BANK0   = 32'h0000_0040;
    localparam word_t OFS_TIMING  = 32'h0000_0080;
    localparam word_t OFS_ECCCFG  = 32'h0000_0094;
    localparam word_t OFS_ECCERR  = 32'h0000_0098;

    // write masks and forced bits
    localparam word_t MSK_REFRESH = 32'h3FF8_0000;
    localparam word_t MSK_TIMING  = 32'h018F_C01F;
    localparam word_t MSK_ECCCFG  = 32'h00F0_0000;
    localparam word_t MSK_PWR     = 32'hF800_0000;
    localparam word_t FRC_PWR     = 32'h07C0_0000;
    localparam word_t MSK_BANK    = 32'hFFDE_E001;

    // reset values
    localparam word_t RST_PWR     = 32'h07C0_0000;
    localparam word_t RST_REFRESH = 32'h05F0_0000;
    localparam word_t RST_TIMING  = 32'h0085_4009;
    localparam word_t RST_CTRL    = 32'h0080_0000;

    localparam int unsigned EN_BIT  = 31;
    localparam int unsigned AUX_BIT = 30;

    typedef struct packed {
        logic [8:0] base;
        logic [2:0] code;
        logic       valid;
    } bank_fld_t;

    function automatic word_t bank_ofs(input int unsigned idx);
        return OFS_BANK0 + word_t'(BANK_STRIDE * idx);
    endfunction

    function automatic bank_fld_t split_bank(input word_t w);
        bank_fld_t f;
        f.base  = w[31:23];
        f.code  = w[19:17];
        f.valid = w[0];
        return f;
    endfunction

    function automatic logic [SIZE_W-1:0] size_mib(input logic [2:0] code);
        logic [SIZE_W-1:0] s;
        s = SIZE_W'(4) << code;
        if (code == 3'd7) s = '0;
        return s;
    endfunction

endpackage

// File: rtl/memcfg_ecc_irq.sv
module memcfg_ecc_irq
    import memcfg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  word_t wdata,
    output word_t err_q,
    output logic  irq_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= '0;
            irq_q <= 1'b0;
        end else if (wr_en) begin
            err_q <= wdata;
            if ((err_q == '0) && (wdata != '0))
                irq_q <= 1'b1;
            else if ((err_q != '0) && (wdata == '0))
                irq_q <= 1'b0;
        end
    end

    // R12
    irq_level_chk: assert property (@(posedge clk) disable iff (rst)
        irq_q == (err_q != '0));

    // R12
    irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (err_q == '0) && (wdata != '0)) |=> irq_q);

endmodule

// File: rtl/memcfg_bank_decode.sv
module memcfg_bank_decode
    import memcfg_pkg::*;
(
    input  bank_fld_t         fld,
    input  logic              enable,
    output word_t             base_addr,
    output logic [SIZE_W-1:0] size_o,
    output logic              mapped
);

    always_comb begin
        base_addr = {fld.base, 23'b0};
        size_o    = size_mib(fld.code);
        mapped    = fld.valid & enable;
    end

endmodule

// File: rtl/memcfg_regfile.sv
module memcfg_regfile
    import memcfg_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      acc_en,
    input  logic      acc_wr,
    input  port_e     acc_port,
    input  word_t     acc_wdata,
    input  word_t     eccerr_i,
    output word_t     rd_data_o,
    output logic      ecc_wr_o,
    output logic      ctrl_en_o,
    output bank_fld_t bank_fld_o [NUM_BANKS]
);

    word_t ptr_q;
    word_t err0_q, err1_q, erraddr_q;
    word_t ctrl_q, stat_q;
    word_t refresh_q, pwr_q, timing_q, ecccfg_q;
    word_t bank_q [NUM_BANKS];

    logic ptr_wr;
    logic data_wr;

    assign ptr_wr  = acc_en && acc_wr && (acc_port == PORT_PTR);
    assign data_wr = acc_en && acc_wr && (acc_port == PORT_DATA);

    assign ecc_wr_o  = data_wr && (ptr_q == OFS_ECCERR);
    assign ctrl_en_o = ctrl_q[EN_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q     <= '0;
            err0_q    <= '0;
            err1_q    <= '0;
            erraddr_q <= '0;
            ctrl_q    <= RST_CTRL;
            stat_q    <= '0;
            refresh_q <= RST_REFRESH;
            pwr_q     <= RST_PWR;
            timing_q  <= RST_TIMING;
            ecccfg_q  <= '0;
        end else begin
            if (ptr_wr)
                ptr_q <= acc_wdata;
            if (data_wr) begin
                case (ptr_q)
                    OFS_ERR0:    err0_q    <= err0_q & ~acc_wdata;
                    OFS_ERR1:    err1_q    <= err1_q & ~acc_wdata;
                    OFS_ERRADDR: erraddr_q <= acc_wdata;
                    OFS_CTRL: begin
                        ctrl_q <= acc_wdata;
                        if (!ctrl_q[EN_BIT] && acc_wdata[EN_BIT])
                            stat_q[EN_BIT] <= 1'b0;
                        else if (ctrl_q[EN_BIT] && !acc_wdata[EN_BIT])
                            stat_q[EN_BIT] <= 1'b1;
                        if (!ctrl_q[AUX_BIT] && acc_wdata[AUX_BIT])
                            stat_q[AUX_BIT] <= 1'b1;
                        else if (ctrl_q[AUX_BIT] && !acc_wdata[AUX_BIT])
                            stat_q[AUX_BIT] <= 1'b0;
                    end
                    OFS_REFRESH: refresh_q <= acc_wdata & MSK_REFRESH;
                    OFS_PWR:     pwr_q     <= (acc_wdata & MSK_PWR) | FRC_PWR;
                    OFS_TIMING:  timing_q  <= acc_wdata & MSK_TIMING;
                    OFS_ECCCFG:  ecccfg_q  <= acc_wdata & MSK_ECCCFG;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int unsigned i = 0; i < NUM_BANKS; i++) begin
            if (rst)
                bank_q[i] <= '0;
            else if (data_wr && (ptr_q == bank_ofs(i)))
                bank_q[i] <= acc_wdata & MSK_BANK;
        end
    end

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_fld
        assign bank_fld_o[g] = split_bank(bank_q[g]);
    end

    always_comb begin
        rd_data_o = '0;
        if (acc_port == PORT_PTR) begin
            rd_data_o = ptr_q;
        end else begin
            case (ptr_q)
                OFS_ERR0:    rd_data_o = err0_q;
                OFS_ERR1:    rd_data_o = err1_q;
                OFS_ERRADDR: rd_data_o = erraddr_q;
                OFS_CTRL:    rd_data_o = ctrl_q;
                OFS_STAT:    rd_data_o = stat_q;
                OFS_REFRESH: rd_data_o = refresh_q;
                OFS_PWR:     rd_data_o = pwr_q;
                OFS_TIMING:  rd_data_o = timing_q;
                OFS_ECCCFG:  rd_data_o = ecccfg_q;
                OFS_ECCERR:  rd_data_o = eccerr_i;
                default:     rd_data_o = '0;
            endcase
            for (int unsigned i = 0; i < NUM_BANKS; i++)
                if (ptr_q == bank_ofs(i)) rd_data_o = bank_q[i];
        end
    end

    // R1
    ptr_load_chk: assert property (@(posedge clk) disable iff (rst)
        ptr_wr |=> (ptr_q == $past(acc_wdata)));

    // R6
    stat_ro_chk: assert property (@(posedge clk) disable iff (rst)
        (data_wr && (ptr_q == OFS_STAT)) |=> $stable(stat_q));

    // R4
    en_rise_stat_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl_q[EN_BIT]) |-> !stat_q[EN_BIT]);

    // R4
    en_fall_stat_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ctrl_q[EN_BIT]) |-> stat_q[EN_BIT]);

    // R5
    aux_follow_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(ctrl_q[AUX_BIT]) || $fell(ctrl_q[AUX_BIT])) |-> (stat_q[AUX_BIT] == ctrl_q[AUX_BIT]));

    // R8
    pwr_forced_chk: assert property (@(posedge clk) disable iff (rst)
        pwr_q[26:22] == 5'h1F);

endmodule

// File: rtl/memctl_cfg_regs.sv
module memctl_cfg_regs
    import memcfg_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          acc_en,
    input  logic                          acc_wr,
    input  logic                          acc_port,
    input  logic [31:0]                   acc_wdata,
    output logic [31:0]                   acc_rdata,
    output logic [NUM_BANKS*DATA_W-1:0]   bank_base,
    output logic [NUM_BANKS*SIZE_W-1:0]   bank_size_mib,
    output logic [NUM_BANKS-1:0]          bank_mapped,
    output logic                          ecc_irq
);

    bank_fld_t bank_fld [NUM_BANKS];
    logic      ctrl_en;
    logic      ecc_wr;
    word_t     eccerr;

    memcfg_regfile #(.NUM_BANKS(NUM_BANKS)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .acc_en     (acc_en),
        .acc_wr     (acc_wr),
        .acc_port   (port_e'(acc_port)),
        .acc_wdata  (acc_wdata),
        .eccerr_i   (eccerr),
        .rd_data_o  (acc_rdata),
        .ecc_wr_o   (ecc_wr),
        .ctrl_en_o  (ctrl_en),
        .bank_fld_o (bank_fld)
    );

    memcfg_ecc_irq u_ecc (
        .clk   (clk),
        .rst   (rst),
        .wr_en (ecc_wr),
        .wdata (acc_wdata),
        .err_q (eccerr),
        .irq_q (ecc_irq)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        memcfg_bank_decode u_dec (
            .fld       (bank_fld[b]),
            .enable    (ctrl_en),
            .base_addr (bank_base[b*DATA_W +: DATA_W]),
            .size_o    (bank_size_mib[b*SIZE_W +: SIZE_W]),
            .mapped    (bank_mapped[b])
        );
    end

    // R11
    mapped_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
        (|bank_mapped) |-> ctrl_en);

    // R11
    disable_unmaps_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ctrl_en) |-> (bank_mapped == '0));

endmodule

// File: tb/memctl_cfg_regs_bench.sv
module memctl_cfg_regs_bench;

    localparam int NB = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              acc_en = 1'b0;
    logic              acc_wr = 1'b0;
    logic              acc_port = 1'b0;
    logic [31:0]       acc_wdata = '0;
    logic [31:0]       acc_rdata;
    logic [NB*32-1:0]  bank_base;
    logic [NB*10-1:0]  bank_size_mib;
    logic [NB-1:0]     bank_mapped;
    logic              ecc_irq;

    memctl_cfg_regs #(.NUM_BANKS(NB)) u_memctl_cfg_regs (
        .clk(clk), .rst(rst), .acc_en(acc_en), .acc_wr(acc_wr),
        .acc_port(acc_port), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .bank_base(bank_base), .bank_size_mib(bank_size_mib),
        .bank_mapped(bank_mapped), .ecc_irq(ecc_irq)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    bit live = 0;

    // behavioural model
    logic [31:0] m_ptr, m_err0, m_err1, m_eaddr, m_cfg, m_stat;
    logic [31:0] m_rfr, m_pwr, m_tim, m_ecfg, m_eerr;
    logic [31:0] m_bank [NB];
    logic        m_irq;

    task automatic model_reset();
        m_ptr = 0; m_err0 = 0; m_err1 = 0; m_eaddr = 0; m_stat = 0;
        m_cfg = 32'h0080_0000; m_rfr = 32'h05F0_0000;
        m_pwr = 32'h07C0_0000; m_tim = 32'h0085_4009;
        m_ecfg = 0; m_eerr = 0; m_irq = 0;
        for (int i = 0; i < NB; i++) m_bank[i] = 0;
    endtask

    function automatic logic [31:0] model_read(input logic [31:0] a);
        logic [31:0] r;
        r = 0;
        if (a == 32'h00) r = m_err0;
        else if (a == 32'h08) r = m_err1;
        else if (a == 32'h10) r = m_eaddr;
        else if (a == 32'h20) r = m_cfg;
        else if (a == 32'h24) r = m_stat;
        else if (a == 32'h30) r = m_rfr;
        else if (a == 32'h34) r = m_pwr;
        else if (a == 32'h80) r = m_tim;
        else if (a == 32'h94) r = m_ecfg;
        else if (a == 32'h98) r = m_eerr;
        for (int i = 0; i < NB; i++)
            if (a == 32'h40 + 32'(4 * i)) r = m_bank[i];
        return r;
    endfunction

    task automatic model_write(input logic [31:0] a, input logic [31:0] v);
        if (a == 32'h00) m_err0 &= ~v;
        else if (a == 32'h08) m_err1 &= ~v;
        else if (a == 32'h10) m_eaddr = v;
        else if (a == 32'h20) begin
            if (!m_cfg[31] && v[31]) m_stat[31] = 0;
            if (m_cfg[31] && !v[31]) m_stat[31] = 1;
            if (!m_cfg[30] && v[30]) m_stat[30] = 1;
            if (m_cfg[30] && !v[30]) m_stat[30] = 0;
            m_cfg = v;
        end
        else if (a == 32'h30) m_rfr = v & 32'h3FF8_0000;
        else if (a == 32'h34) m_pwr = (v & 32'hF800_0000) | 32'h07C0_0000;
        else if (a == 32'h80) m_tim = v & 32'h018F_C01F;
        else if (a == 32'h94) m_ecfg = v & 32'h00F0_0000;
        else if (a == 32'h98) begin
            if (m_eerr == 0 && v != 0) m_irq = 1;
            if (m_eerr != 0 && v == 0) m_irq = 0;
            m_eerr = v;
        end
        for (int i = 0; i < NB; i++)
            if (a == 32'h40 + 32'(4 * i)) m_bank[i] = v & 32'hFFDE_E001;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // per-cycle comparison of registered outputs
    always @(negedge clk) begin
        if (live && !rst) begin
            for (int i = 0; i < NB; i++) begin
                logic [2:0] code;
                logic [31:0] esz;
                code = m_bank[i][19:17];
                esz = (code == 3'd7) ? 32'd0 : (32'd4 << code);
                // R10
                check("R10 base", bank_base[i*32 +: 32], m_bank[i] & 32'hFF80_0000);
                check("R10 size", 32'(bank_size_mib[i*10 +: 10]), esz);
                // R11
                check("R11 mapped", 32'(bank_mapped[i]), 32'(m_bank[i][0] & m_cfg[31]));
            end
            // R12
            check("R12 irq", 32'(ecc_irq), 32'(m_irq));
        end
    end

    task automatic wr(input logic port, input logic [31:0] v);
        @(negedge clk);
        acc_en = 1; acc_wr = 1; acc_port = port; acc_wdata = v;
        @(posedge clk);
        #1;
        if (port) model_write(m_ptr, v); else m_ptr = v;
        acc_en = 0; acc_wr = 0;
    endtask

    task automatic rd_ptr(input string req);
        @(negedge clk);
        acc_port = 0;
        #1 check(req, acc_rdata, m_ptr);
    endtask

    task automatic rd_data(input string req);
        @(negedge clk);
        acc_port = 1;
        #1 check(req, acc_rdata, model_read(m_ptr));
    endtask

    task automatic wr_reg(input logic [31:0] a, input logic [31:0] v);
        wr(0, a);
        wr(1, v);
    endtask

    task automatic rd_reg(input logic [31:0] a, input string req);
        wr(0, a);
        rd_data(req);
    endtask

    task automatic sweep(input string req);
        logic [31:0] offs [15];
        offs = '{32'h00, 32'h08, 32'h10, 32'h20, 32'h24, 32'h30, 32'h34,
                 32'h40, 32'h44, 32'h48, 32'h4C, 32'h80, 32'h94, 32'h98, 32'h50};
        for (int i = 0; i < 15; i++) rd_reg(offs[i], req);
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst = 0;
        live = 1;
        // R2 reset values via both ports
        rd_ptr("R2 pointer");
        sweep("R2 reset");
        // R1 pointer readback
        wr(0, 32'hA5A5_0030);
        rd_ptr("R1 pointer readback");
        rd_data("R13 high pointer bits");
        // R7 masks
        wr_reg(32'h30, 32'hFFFF_FFFF); rd_data("R7 refresh");
        wr_reg(32'h80, 32'hFFFF_FFFF); rd_data("R7 timing");
        wr_reg(32'h94, 32'hFFFF_FFFF); rd_data("R7 ecc cfg");
        wr_reg(32'h30, 32'h1234_5678); rd_data("R7 refresh pattern");
        // R8 power management
        wr_reg(32'h34, 32'h0000_0000); rd_data("R8 forced");
        wr_reg(32'h34, 32'hFFFF_FFFF); rd_data("R8 all ones");
        // R6 status read-only
        wr_reg(32'h24, 32'hFFFF_FFFF); rd_data("R6 status");
        // R3 error registers
        wr_reg(32'h00, 32'hFFFF_FFFF); rd_data("R3 err0");
        wr_reg(32'h08, 32'h0F0F_0F0F); rd_data("R3 err1");
        wr_reg(32'h10, 32'hDEAD_BEEF); rd_data("R3 error address");
        // R9 bank storage, R10 decode, R11 with enable clear
        wr_reg(32'h40, 32'hFFFF_FFFF); rd_data("R9 bank0");
        wr_reg(32'h44, 32'h1A0D_FFFF); rd_data("R9 bank1");
        wr_reg(32'h48, 32'h0080_0001); rd_data("R9 bank2");
        wr_reg(32'h4C, 32'h3006_0000); rd_data("R9 bank3");
        // R4 / R5 configuration edges
        wr_reg(32'h20, 32'h8000_0000); rd_reg(32'h24, "R4 enable rise");
        wr_reg(32'h20, 32'hC000_0000); rd_reg(32'h24, "R5 aux rise");
        rd_reg(32'h20, "R4 cfg stored");
        wr_reg(32'h44, 32'h0000_0000); rd_data("R9 bank1 cleared");
        wr_reg(32'h44, 32'hFF8C_0001); rd_data("R10 code6 bank");
        wr_reg(32'h20, 32'h0000_0000); rd_reg(32'h24, "R4 enable fall");
        wr_reg(32'h20, 32'h4000_0000); rd_reg(32'h24, "R5 aux only");
        wr_reg(32'h20, 32'h8000_0000); rd_reg(32'h24, "R5 aux fall");
        // R12 ECC interrupt
        wr_reg(32'h98, 32'h0000_0005); rd_data("R12 err value");
        wr_reg(32'h98, 32'h0000_0007); rd_data("R12 second nonzero");
        wr_reg(32'h98, 32'h0000_0000); rd_data("R12 cleared");
        wr_reg(32'h98, 32'h8000_0000); rd_data("R12 again");
        // R13 unmapped offsets
        wr_reg(32'h04, 32'hFFFF_FFFF); rd_data("R13 0x04");
        wr_reg(32'h50, 32'hFFFF_FFFF); rd_data("R13 0x50");
        wr_reg(32'h0000_0120, 32'hFFFF_FFFF); rd_data("R13 0x120");
        wr_reg(32'h0100_0020, 32'h0000_0000); rd_data("R13 aliased ctrl");
        sweep("R13 no side effect");
        repeat (2) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule